// File: doc/BRIEF.md
# Bridge Error Logger and Escalator

This block gathers error events from the two sides of a bus bridge. One side is the serial upstream link and the other is the parallel secondary bus. Each uncorrectable event sets a status bit of its own, which is sticky and cleared by writing 1. The first unmasked event on each side also freezes a copy of the transaction header and a pointer to the error that caused it. The header log stays frozen until software clears the status bit that the pointer names. The block then decides whether the event becomes a fatal, non-fatal or correctable message request toward the upstream port. That decision combines per-error mask and severity bits, the two message-type enables, the global system-error enable, and two bridge-control overrides.

Configuration arrives as single-cycle register writes from an external decoder. Masks, severities and enable bits are held here. Status and log contents are exposed as plain output ports.

There are two reset levels. The power-on reset clears everything. The warm reset clears configuration, the correctable and system-error status bits and the message outputs. It leaves the uncorrectable status, the header logs and the first-error pointers untouched.

Top module: `berr_bridge_log`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` by `cfg_addr`:
  - 0 is the link-side mask.
  - 1 is the link-side severity, where 1 means fatal.
  - 2 is the secondary-side mask.
  - 3 is the secondary-side severity.
  - 4 is control. Bit 0 is the system-error enable, bit 1 the fatal enable, bit 2 the non-fatal enable, bit 3 the correctable enable, bit 4 the SERR forward enable and bit 5 the master-abort mode.
  - 5 and 6 clear link-side and secondary-side status bits written as 1.
  - 7 clears the correctable status with bit 0 and the system-error status with bit 1.
- R2: Each error pulse sets its status bit on the next clock edge, whatever the mask. A write-1-to-clear resets the bit. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R3: On each side, the first error whose mask bit is clear captures the header and sets the pointer, and the valid flag rises. Among simultaneous errors, the lowest index is chosen. Later errors and masked errors leave the log unchanged.
- R4: The log on a side re-arms only when software clears the status bit the pointer names. Clearing any other bit leaves the log valid and frozen.
- R5: Generic uncorrectable errors are all link-side bits and secondary bits 5 and up. Such an error requests a fatal message when its severity is 1, or a non-fatal message when its severity is 0, only if its mask is clear. A fatal request also needs the system-error enable or the fatal enable. A non-fatal request needs the system-error enable or the non-fatal enable, and never the fatal enable.
- R6: Secondary bit 0 (SERR seen on the bus) passes when the forward enable is set or its mask is clear. It is then subject to the same type enables as R5.
- R7: Secondary bit 1 (master abort on a posted write) passes when master-abort mode is set or its mask is clear. It is then subject to the R5 type enables.
- R8: Secondary bits 2 and 3 (target abort, and data parity on a posted write) pass when the system-error enable is set, even when masked, or when the mask is clear. They are then subject to the R5 type enables.
- R9: Secondary bit 4 is a parity error on poisoned data that the bridge itself forwarded. It sets status and may log a header, but it never requests a message.
- R10: A correctable pulse always sets the correctable status. It requests a correctable message only when the correctable enable is set.
- R11: The system-error status sets in any cycle where a fatal or non-fatal request is issued while the system-error enable is set.
- R12: Messages and status appear one cycle after the event. A warm reset keeps the uncorrectable status bits, the logs and the pointers. It clears configuration, the correctable status, the system-error status and the messages. A power-on reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous |
| up_err | input | N_ERR | Link-side uncorrectable error pulses |
| up_hdr | input | HDR_W | Header word of the link-side event |
| sb_err | input | N_ERR | Secondary-side uncorrectable error pulses |
| sb_hdr | input | HDR_W | Header word of the secondary-side event |
| cor_err | input | 1 | Correctable ECC error pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | N_ERR | Configuration write data |
| msg_fatal | output | 1 | Fatal message request |
| msg_nonfatal | output | 1 | Non-fatal message request |
| msg_cor | output | 1 | Correctable message request |
| up_sts | output | N_ERR | Link-side uncorrectable status |
| sb_sts | output | N_ERR | Secondary-side uncorrectable status |
| cor_sts | output | 1 | Correctable error detected |
| sse_sts | output | 1 | System error signaled |
| up_log_vld | output | 1 | Link-side header log holds a capture |
| up_fep | output | clog2(N_ERR) | Link-side first-error pointer |
| up_hdr_log | output | HDR_W | Link-side captured header |
| sb_log_vld | output | 1 | Secondary-side header log holds a capture |
| sb_fep | output | clog2(N_ERR) | Secondary-side first-error pointer |
| sb_hdr_log | output | HDR_W | Secondary-side captured header |

## Verification
The bench sweeps every error bit on both sides against every combination of mask, severity, system-error enable, both type enables and both bridge overrides. This would catch swapped enables, where a fatal event would be gated by the non-fatal bit. It would also catch a missing OR override, where a masked target abort would be dropped while the system-error enable is set, or a poisoned-parity event that leaks a message. The log tests go after lock and re-arm. A design that re-arms on clearing any bit would overwrite the header, and one that ignores priority would point at the wrong bit of a simultaneous pair. A warm reset in the middle of a run checks that the sticky logs survive while configuration is lost, which a single-reset design would get wrong.

// File: rtl/berr_pkg.sv
package berr_pkg;

  // control register fields, assigned explicitly from write data bits
  typedef struct packed {
    logic ma_mode;
    logic serr_fwd;
    logic cor_en;
    logic nonfatal_en;
    logic fatal_en;
    logic serr_en;
  } berr_ctl_t;

  typedef enum logic [2:0] {
    A_UP_MASK  = 3'd0,
    A_UP_SEV   = 3'd1,
    A_SB_MASK  = 3'd2,
    A_SB_SEV   = 3'd3,
    A_CTL      = 3'd4,
    A_UP_CLR   = 3'd5,
    A_SB_CLR   = 3'd6,
    A_MISC_CLR = 3'd7
  } berr_addr_e;

  // secondary-side bit positions whose escalation differs
  localparam int SB_SERR   = 0;
  localparam int SB_MA     = 1;
  localparam int SB_TA     = 2;
  localparam int SB_DPE    = 3;
  localparam int SB_POISON = 4;

  typedef enum logic [2:0] {
    RULE_PLAIN,
    RULE_SERR_FWD,
    RULE_MA,
    RULE_FORCE,
    RULE_SILENT
  } berr_rule_e;

  function automatic berr_rule_e rule_for(input bit sb_side, input int idx);
    if (!sb_side) return RULE_PLAIN;
    case (idx)
      SB_SERR:        return RULE_SERR_FWD;
      SB_MA:          return RULE_MA;
      SB_TA, SB_DPE:  return RULE_FORCE;
      SB_POISON:      return RULE_SILENT;
      default:        return RULE_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/berr_rst_sync.sv
module berr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  // assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/berr_cfg.sv
module berr_cfg
  import berr_pkg::*;
#(
  parameter int N_ERR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [N_ERR-1:0] wdata,
  output logic [N_ERR-1:0] up_mask,
  output logic [N_ERR-1:0] up_sev,
  output logic [N_ERR-1:0] sb_mask,
  output logic [N_ERR-1:0] sb_sev,
  output berr_ctl_t        ctl,
  output logic [N_ERR-1:0] up_clr,
  output logic [N_ERR-1:0] sb_clr,
  output logic             cor_clr,
  output logic             sse_clr
);
  logic      wr_upm, wr_ups, wr_sbm, wr_sbs, wr_ctl;
  berr_ctl_t ctl_d;

  always_comb begin
    wr_upm  = we && (addr == A_UP_MASK);
    wr_ups  = we && (addr == A_UP_SEV);
    wr_sbm  = we && (addr == A_SB_MASK);
    wr_sbs  = we && (addr == A_SB_SEV);
    wr_ctl  = we && (addr == A_CTL);
    ctl_d.serr_en     = wdata[0];
    ctl_d.fatal_en    = wdata[1];
    ctl_d.nonfatal_en = wdata[2];
    ctl_d.cor_en      = wdata[3];
    ctl_d.serr_fwd    = wdata[4];
    ctl_d.ma_mode     = wdata[5];
    up_clr  = (we && (addr == A_UP_CLR)) ? wdata : '0;
    sb_clr  = (we && (addr == A_SB_CLR)) ? wdata : '0;
    cor_clr = we && (addr == A_MISC_CLR) && wdata[0];
    sse_clr = we && (addr == A_MISC_CLR) && wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_mask <= '0;
      up_sev  <= '0;
      sb_mask <= '0;
      sb_sev  <= '0;
      ctl     <= '0;
    end else begin
      if (wr_upm) up_mask <= wdata;
      if (wr_ups) up_sev  <= wdata;
      if (wr_sbm) sb_mask <= wdata;
      if (wr_sbs) sb_sev  <= wdata;
      if (wr_ctl) ctl     <= ctl_d;
    end
  end
endmodule

// File: rtl/berr_log.sv
module berr_log #(
  parameter int N_ERR = 8,
  parameter int HDR_W = 32,
  localparam int IW   = $clog2(N_ERR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] err,
  input  logic [N_ERR-1:0] mask,
  input  logic [HDR_W-1:0] hdr,
  input  logic [N_ERR-1:0] clr,
  output logic [N_ERR-1:0] sts,
  output logic             log_vld,
  output logic [IW-1:0]    fep,
  output logic [HDR_W-1:0] hdr_log
);
  logic [N_ERR-1:0] cand, sts_d;
  logic [IW-1:0]    pick, fep_d;
  logic             rearm, cap, vld_d;

  always_comb begin
    cand = err & ~mask;
    pick = '0;
    for (int i = N_ERR - 1; i >= 0; i--) begin
      if (cand[i]) pick = IW'(i);
    end
    rearm = log_vld && clr[fep];
    cap   = (|cand) && (!log_vld || rearm);
    sts_d = (sts & ~clr) | err;
    vld_d = cap ? 1'b1 : (rearm ? 1'b0 : log_vld);
    fep_d = cap ? pick : fep;
  end

  // sticky state: only the power-on domain reset reaches these flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= '0;
      log_vld <= 1'b0;
      fep     <= '0;
      hdr_log <= '0;
    end else begin
      sts     <= sts_d;
      log_vld <= vld_d;
      fep     <= fep_d;
      if (cap) hdr_log <= hdr;
    end
  end
endmodule

// File: rtl/berr_escalate.sv
module berr_escalate
  import berr_pkg::*;
#(
  parameter int N_ERR   = 8,
  parameter bit SB_SIDE = 1'b0
) (
  input  logic [N_ERR-1:0] err,
  input  logic [N_ERR-1:0] mask,
  input  logic [N_ERR-1:0] sev,
  input  berr_ctl_t        ctl,
  output logic             fatal_req,
  output logic             nonfatal_req
);
  logic [N_ERR-1:0] pass;
  logic             ctl_unused;

  assign ctl_unused = ctl.serr_fwd ^ ctl.ma_mode ^ ctl.cor_en;

  for (genvar i = 0; i < N_ERR; i++) begin : g_bit
    localparam berr_rule_e RULE = rule_for(SB_SIDE, i);
    if (RULE == RULE_SERR_FWD) begin : g_fwd
      assign pass[i] = ctl.serr_fwd | ~mask[i];
    end else if (RULE == RULE_MA) begin : g_ma
      assign pass[i] = ctl.ma_mode | ~mask[i];
    end else if (RULE == RULE_FORCE) begin : g_force
      assign pass[i] = ctl.serr_en | ~mask[i];
    end else if (RULE == RULE_SILENT) begin : g_silent
      logic mask_unused;
      assign mask_unused = mask[i];
      assign pass[i]     = 1'b0;
    end else begin : g_plain
      assign pass[i] = ~mask[i];
    end
  end

  always_comb begin
    fatal_req    = (|(err & pass & sev))  && (ctl.serr_en || ctl.fatal_en);
    nonfatal_req = (|(err & pass & ~sev)) && (ctl.serr_en || ctl.nonfatal_en);
  end
endmodule

// File: rtl/berr_bridge_log.sv
module berr_bridge_log
  import berr_pkg::*;
#(
  parameter int N_ERR = 8,
  parameter int HDR_W = 32
) (
  input  logic                     clk,
  input  logic                     por_rst_n,
  input  logic                     warm_rst_n,
  input  logic [N_ERR-1:0]         up_err,
  input  logic [HDR_W-1:0]         up_hdr,
  input  logic [N_ERR-1:0]         sb_err,
  input  logic [HDR_W-1:0]         sb_hdr,
  input  logic                     cor_err,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [N_ERR-1:0]         cfg_wdata,
  output logic                     msg_fatal,
  output logic                     msg_nonfatal,
  output logic                     msg_cor,
  output logic [N_ERR-1:0]         up_sts,
  output logic [N_ERR-1:0]         sb_sts,
  output logic                     cor_sts,
  output logic                     sse_sts,
  output logic                     up_log_vld,
  output logic [$clog2(N_ERR)-1:0] up_fep,
  output logic [HDR_W-1:0]         up_hdr_log,
  output logic                     sb_log_vld,
  output logic [$clog2(N_ERR)-1:0] sb_fep,
  output logic [HDR_W-1:0]         sb_hdr_log
);
  logic             cold_n, warm_n, warm_src_n;
  logic [N_ERR-1:0] up_mask, up_sev, sb_mask, sb_sev, up_clr, sb_clr;
  logic             cor_clr, sse_clr;
  berr_ctl_t        ctl;
  logic             up_fat, up_nf, sb_fat, sb_nf;
  logic             fat_d, nf_d, cmsg_d, cor_sts_d, sse_d;

  assign warm_src_n = por_rst_n & warm_rst_n;

  berr_rst_sync u_cold_sync (.clk(clk), .arst_n(por_rst_n),  .srst_n(cold_n));
  berr_rst_sync u_warm_sync (.clk(clk), .arst_n(warm_src_n), .srst_n(warm_n));

  berr_cfg #(.N_ERR(N_ERR)) u_cfg (
    .clk(clk), .rst_n(warm_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .up_mask(up_mask), .up_sev(up_sev), .sb_mask(sb_mask), .sb_sev(sb_sev),
    .ctl(ctl), .up_clr(up_clr), .sb_clr(sb_clr), .cor_clr(cor_clr), .sse_clr(sse_clr)
  );

  berr_log #(.N_ERR(N_ERR), .HDR_W(HDR_W)) u_up_log (
    .clk(clk), .rst_n(cold_n), .err(up_err), .mask(up_mask), .hdr(up_hdr),
    .clr(up_clr), .sts(up_sts), .log_vld(up_log_vld), .fep(up_fep), .hdr_log(up_hdr_log)
  );

  berr_log #(.N_ERR(N_ERR), .HDR_W(HDR_W)) u_sb_log (
    .clk(clk), .rst_n(cold_n), .err(sb_err), .mask(sb_mask), .hdr(sb_hdr),
    .clr(sb_clr), .sts(sb_sts), .log_vld(sb_log_vld), .fep(sb_fep), .hdr_log(sb_hdr_log)
  );

  berr_escalate #(.N_ERR(N_ERR), .SB_SIDE(1'b0)) u_up_esc (
    .err(up_err), .mask(up_mask), .sev(up_sev), .ctl(ctl),
    .fatal_req(up_fat), .nonfatal_req(up_nf)
  );

  berr_escalate #(.N_ERR(N_ERR), .SB_SIDE(1'b1)) u_sb_esc (
    .err(sb_err), .mask(sb_mask), .sev(sb_sev), .ctl(ctl),
    .fatal_req(sb_fat), .nonfatal_req(sb_nf)
  );

  always_comb begin
    fat_d     = up_fat | sb_fat;
    nf_d      = up_nf | sb_nf;
    cmsg_d    = cor_err & ctl.cor_en;
    cor_sts_d = (cor_sts & ~cor_clr) | cor_err;
    sse_d     = (sse_sts & ~sse_clr) | ((fat_d | nf_d) & ctl.serr_en);
  end

  always_ff @(posedge clk or negedge warm_n) begin
    if (!warm_n) begin
      msg_fatal    <= 1'b0;
      msg_nonfatal <= 1'b0;
      msg_cor      <= 1'b0;
      cor_sts      <= 1'b0;
      sse_sts      <= 1'b0;
    end else begin
      msg_fatal    <= fat_d;
      msg_nonfatal <= nf_d;
      msg_cor      <= cmsg_d;
      cor_sts      <= cor_sts_d;
      sse_sts      <= sse_d;
    end
  end
endmodule

// File: rtl/berr_bridge_log_chk.sv
module berr_bridge_log_chk
  import berr_pkg::*;
#(
  parameter int N_ERR = 8,
  parameter int HDR_W = 32
) (
  input logic                     clk,
  input logic                     cold_n,
  input logic                     warm_n,
  input berr_ctl_t                ctl,
  input logic                     msg_fatal,
  input logic                     msg_nonfatal,
  input logic                     msg_cor,
  input logic                     sse_sts,
  input logic [N_ERR-1:0]         up_sts,
  input logic [N_ERR-1:0]         up_clr,
  input logic                     up_log_vld,
  input logic [$clog2(N_ERR)-1:0] up_fep,
  input logic [HDR_W-1:0]         up_hdr_log,
  input logic [N_ERR-1:0]         sb_sts,
  input logic [N_ERR-1:0]         sb_clr,
  input logic                     sb_log_vld,
  input logic [$clog2(N_ERR)-1:0] sb_fep,
  input logic [HDR_W-1:0]         sb_hdr_log
);
  assert_fatal_gate_R5: assert property (@(posedge clk) disable iff (!warm_n)
    msg_fatal |-> $past(ctl.serr_en || ctl.fatal_en));

  assert_nonfatal_gate_R5: assert property (@(posedge clk) disable iff (!warm_n)
    msg_nonfatal |-> $past(ctl.serr_en || ctl.nonfatal_en));

  assert_cor_gate_R10: assert property (@(posedge clk) disable iff (!warm_n)
    msg_cor |-> $past(ctl.cor_en));

  assert_sse_cause_R11: assert property (@(posedge clk) disable iff (!warm_n)
    $rose(sse_sts) |-> ((msg_fatal || msg_nonfatal) && $past(ctl.serr_en)));

  assert_up_log_frozen_R4: assert property (@(posedge clk) disable iff (!cold_n)
    (up_log_vld && !up_clr[up_fep]) |=> (up_log_vld && $stable(up_hdr_log) && $stable(up_fep)));

  assert_sb_log_frozen_R4: assert property (@(posedge clk) disable iff (!cold_n)
    (sb_log_vld && !sb_clr[sb_fep]) |=> (sb_log_vld && $stable(sb_hdr_log) && $stable(sb_fep)));

  assert_up_ptr_status_R3: assert property (@(posedge clk) disable iff (!cold_n)
    up_log_vld |-> up_sts[up_fep]);

  assert_sb_ptr_status_R3: assert property (@(posedge clk) disable iff (!cold_n)
    sb_log_vld |-> sb_sts[sb_fep]);
endmodule

bind berr_bridge_log berr_bridge_log_chk #(.N_ERR(N_ERR), .HDR_W(HDR_W)) u_chk (
  .clk(clk), .cold_n(cold_n), .warm_n(warm_n), .ctl(ctl),
  .msg_fatal(msg_fatal), .msg_nonfatal(msg_nonfatal), .msg_cor(msg_cor), .sse_sts(sse_sts),
  .up_sts(up_sts), .up_clr(up_clr), .up_log_vld(up_log_vld), .up_fep(up_fep),
  .up_hdr_log(up_hdr_log), .sb_sts(sb_sts), .sb_clr(sb_clr), .sb_log_vld(sb_log_vld),
  .sb_fep(sb_fep), .sb_hdr_log(sb_hdr_log)
);

// File: tb/berr_bridge_log_tb.sv
module berr_bridge_log_tb;
  localparam int N  = 8;
  localparam int HW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          por_rst_n, warm_rst_n;
  logic [N-1:0]  up_err, sb_err, cfg_wdata;
  logic [HW-1:0] up_hdr, sb_hdr;
  logic          cor_err, cfg_we;
  logic [2:0]    cfg_addr;
  logic          msg_fatal, msg_nonfatal, msg_cor, cor_sts, sse_sts;
  logic [N-1:0]  up_sts, sb_sts;
  logic          up_log_vld, sb_log_vld;
  logic [IW-1:0] up_fep, sb_fep;
  logic [HW-1:0] up_hdr_log, sb_hdr_log;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  berr_bridge_log #(.N_ERR(N), .HDR_W(HW)) u_dut (
    .clk(clk), .por_rst_n(por_rst_n), .warm_rst_n(warm_rst_n),
    .up_err(up_err), .up_hdr(up_hdr), .sb_err(sb_err), .sb_hdr(sb_hdr), .cor_err(cor_err),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .msg_fatal(msg_fatal), .msg_nonfatal(msg_nonfatal), .msg_cor(msg_cor),
    .up_sts(up_sts), .sb_sts(sb_sts), .cor_sts(cor_sts), .sse_sts(sse_sts),
    .up_log_vld(up_log_vld), .up_fep(up_fep), .up_hdr_log(up_hdr_log),
    .sb_log_vld(sb_log_vld), .sb_fep(sb_fep), .sb_hdr_log(sb_hdr_log)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [N-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0;
  endtask

  task automatic clear_all();
    cfg_wr(3'd5, '1);
    cfg_wr(3'd6, '1);
    cfg_wr(3'd7, '1);
  endtask

  task automatic pulse(input logic [N-1:0] u, input logic [HW-1:0] uh,
                       input logic [N-1:0] s, input logic [HW-1:0] sh, input logic c);
    up_err = u; up_hdr = uh; sb_err = s; sb_hdr = sh; cor_err = c;
    @(negedge clk);
    up_err = '0; sb_err = '0; cor_err = 1'b0;
  endtask

  // expected {fatal, nonfatal} from the escalation requirements
  function automatic logic [1:0] exp_msg(input bit sb, input int b, input bit m, input bit s,
                                         input bit se, input bit fe, input bit ne,
                                         input bit fwd, input bit ma);
    bit pass;
    if (!sb || b > 4) pass = !m;
    else if (b == 0)  pass = fwd || !m;
    else if (b == 1)  pass = ma || !m;
    else if (b <= 3)  pass = se || !m;
    else              pass = 1'b0;
    return {pass && s && (se || fe), pass && !s && (se || ne)};
  endfunction

  function automatic string tag_of(input bit sb, input int b);
    if (!sb || b > 4) return "R5";
    if (b == 0) return "R6";
    if (b == 1) return "R7";
    if (b <= 3) return "R8";
    return "R9";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] e;
    por_rst_n = 1'b0; warm_rst_n = 1'b1;
    up_err = '0; sb_err = '0; up_hdr = '0; sb_hdr = '0; cor_err = 1'b0;
    cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state, R12
    chk("R12", "reset up_sts", 64'(up_sts), 64'h0);
    chk("R12", "reset sb_sts", 64'(sb_sts), 64'h0);
    chk("R12", "reset logs", 64'({up_log_vld, sb_log_vld}), 64'h0);
    chk("R12", "reset msgs", 64'({msg_fatal, msg_nonfatal, msg_cor, cor_sts, sse_sts}), 64'h0);

    // first-error capture with priority, R2 R3
    pulse(8'h24, 32'hA0A0_0001, '0, '0, 1'b0);
    chk("R2", "up_sts after pair", 64'(up_sts), 64'h24);
    chk("R3", "log valid", 64'(up_log_vld), 64'h1);
    chk("R3", "pointer lowest", 64'(up_fep), 64'h2);
    chk("R3", "header", 64'(up_hdr_log), 64'hA0A0_0001);
    pulse(8'h01, 32'hB0B0_0002, '0, '0, 1'b0);
    chk("R2", "up_sts accumulate", 64'(up_sts), 64'h25);
    chk("R3", "later error keeps header", 64'(up_hdr_log), 64'hA0A0_0001);
    chk("R3", "later error keeps pointer", 64'(up_fep), 64'h2);

    // re-arm only through the pointed bit, R4
    cfg_wr(3'd5, 8'h01);
    chk("R2", "w1c bit0", 64'(up_sts), 64'h24);
    chk("R4", "other clear keeps lock", 64'({up_log_vld, up_hdr_log}), {31'd0, 1'b1, 32'hA0A0_0001});
    cfg_wr(3'd5, 8'h04);
    chk("R4", "pointed clear unlocks", 64'(up_log_vld), 64'h0);
    pulse(8'h20, 32'hC0C0_0003, '0, '0, 1'b0);
    chk("R4", "recapture pointer", 64'(up_fep), 64'h5);
    chk("R4", "recapture header", 64'(up_hdr_log), 64'hC0C0_0003);

    // set wins over same-cycle clear, R2
    up_err = 8'h08; cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 8'h08;
    @(negedge clk);
    up_err = '0; cfg_we = 1'b0; cfg_wdata = '0;
    chk("R2", "set beats clear", 64'(up_sts[3]), 64'h1);

    // masked error does not log, R1 R3
    clear_all();
    cfg_wr(3'd2, 8'h02);
    pulse('0, '0, 8'h02, 32'hD0D0_0004, 1'b0);
    chk("R1", "masked still sets status", 64'(sb_sts), 64'h02);
    chk("R3", "masked no log", 64'(sb_log_vld), 64'h0);
    pulse('0, '0, 8'h42, 32'hE0E0_0005, 1'b0);
    chk("R3", "unmasked logged past masked", 64'({sb_fep, sb_hdr_log}), {29'd0, 3'd6, 32'hE0E0_0005});
    cfg_wr(3'd2, '0);
    clear_all();

    // link-side escalation sweep, R5
    for (int b = 0; b < N; b++) begin
      for (int c = 0; c < 32; c++) begin
        e = exp_msg(1'b0, b, c[0], c[1], c[2], c[3], c[4], 1'b0, 1'b0);
        cfg_wr(3'd0, N'(c[0]) << b);
        cfg_wr(3'd1, N'(c[1]) << b);
        cfg_wr(3'd4, N'({c[4], c[3], c[2]}));
        pulse(N'(1) << b, HW'(b * 256 + c), '0, '0, 1'b0);
        chk("R5", "fatal", 64'(msg_fatal), 64'(e[1]));
        chk("R5", "nonfatal", 64'(msg_nonfatal), 64'(e[0]));
        chk("R2", "status bit", 64'(up_sts), 64'(N'(1) << b));
        chk("R3", "log on unmasked", 64'(up_log_vld), 64'(!c[0]));
        chk("R11", "sse", 64'(sse_sts), 64'((e[1] || e[0]) && c[2]));
        clear_all();
      end
    end
    cfg_wr(3'd0, '0);
    cfg_wr(3'd1, '0);

    // secondary-side escalation sweep, R5 to R9
    for (int b = 0; b < N; b++) begin
      for (int c = 0; c < 128; c++) begin
        e = exp_msg(1'b1, b, c[0], c[1], c[2], c[3], c[4], c[5], c[6]);
        cfg_wr(3'd2, N'(c[0]) << b);
        cfg_wr(3'd3, N'(c[1]) << b);
        cfg_wr(3'd4, N'({c[6], c[5], 1'b0, c[4], c[3], c[2]}));
        pulse('0, '0, N'(1) << b, HW'(b * 256 + c), 1'b0);
        chk(tag_of(1'b1, b), "fatal", 64'(msg_fatal), 64'(e[1]));
        chk(tag_of(1'b1, b), "nonfatal", 64'(msg_nonfatal), 64'(e[0]));
        chk(tag_of(1'b1, b), "status bit", 64'(sb_sts), 64'(N'(1) << b));
        chk(tag_of(1'b1, b), "log on unmasked", 64'(sb_log_vld), 64'(!c[0]));
        chk("R11", "sse", 64'(sse_sts), 64'((e[1] || e[0]) && c[2]));
        clear_all();
      end
    end
    cfg_wr(3'd2, '0);
    cfg_wr(3'd3, '0);

    // correctable path, R10
    for (int ce = 0; ce < 2; ce++) begin
      cfg_wr(3'd4, N'(ce << 3));
      pulse('0, '0, '0, '0, 1'b1);
      chk("R10", "cor msg", 64'(msg_cor), 64'(ce));
      chk("R10", "cor status", 64'(cor_sts), 64'h1);
      chk("R10", "no uncorrectable msg", 64'({msg_fatal, msg_nonfatal}), 64'h0);
      cfg_wr(3'd7, 8'h01);
      chk("R10", "cor status cleared", 64'(cor_sts), 64'h0);
    end

    // warm reset keeps sticky state, power-on reset clears it, R12
    clear_all();
    cfg_wr(3'd4, 8'h01);
    pulse('0, '0, 8'h04, 32'hF0F0_0006, 1'b1);
    chk("R12", "sse before warm", 64'(sse_sts), 64'h1);
    warm_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    warm_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "status kept", 64'(sb_sts), 64'h04);
    chk("R12", "log kept", 64'({sb_log_vld, sb_fep, sb_hdr_log}), {28'd0, 1'b1, 3'd2, 32'hF0F0_0006});
    chk("R12", "volatile cleared", 64'({cor_sts, sse_sts}), 64'h0);
    pulse('0, '0, 8'h20, 32'h1, 1'b0);
    chk("R12", "enables lost", 64'({msg_fatal, msg_nonfatal}), 64'h0);
    por_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "cold clears status", 64'(sb_sts), 64'h0);
    chk("R12", "cold clears log", 64'({sb_log_vld, sb_fep, sb_hdr_log}), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule